// File: doc/BRIEF.md
# Programmable Counter/Timer with Selectable Tick Source

This block is a 16-bit down-counter that works in one of two ways, chosen by a 3-bit mode field. As a timer it never stops. It counts down from a stored preload value, reloads itself, and flips its output bit at every reload, so the output is a square wave. As a counter it is a one-shot. A start command loads the preload value and the count falls by one on each selected tick. When the count reaches the end, the output drops low and stays low until a stop command raises it again.

The same mode field also picks where the ticks come from. The choices are:
- a pin that is synchronized inside the block;
- that pin's rising edges divided by 16;
- either of two 1x transmit clock enables;
- the system clock;
- the system clock divided by 16.

A terminal-count flag marks each end-of-count event. A stop command clears it.

Top module: `ctr_timer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `ct_out` is 1 and `tc_flag` is 0.
- R2: `mode_sel` picks the mode and the tick source. Bit 2 = 0 is counter mode and bit 2 = 1 is timer mode. The codes are:
  - 000: counter, ticked by rising edges of `ext_pin`.
  - 001: counter, ticked by `txa_tick`.
  - 010: counter, ticked by `txb_tick`.
  - 011: counter, ticked by the clock divided by 16.
  - 100: timer, ticked by rising edges of `ext_pin`.
  - 101: timer, ticked by those rising edges divided by 16.
  - 110: timer, ticked by every clock.
  - 111: timer, ticked by the clock divided by 16.
- R3: In counter mode, `start_cmd` copies the stored preload into the count. Each selected tick while running lowers the count by one. A tick at count 1 is terminal; a preload of 0 acts as 1. A terminal tick makes `ct_out` 0 and `tc_flag` 1 on the next cycle and halts counting.
- R4: In counter mode, once `ct_out` is 0 it stays 0 through further ticks and through new start commands. Only a stop command changes it.
- R5: In counter mode, `stop_cmd` sets `ct_out` to 1 and `tc_flag` to 0 and halts counting. If start and stop arrive in the same cycle, stop wins.
- R6: In counter mode, ticks that arrive while the counter is halted have no effect. Ticks from a source that the mode does not select also have no effect.
- R7: In timer mode, the count runs at all times. A tick at count 1 or 0 reloads the preload, inverts `ct_out` and sets `tc_flag`, so each output half-period lasts `preload` ticks. `start_cmd` reloads the count without inverting the output.
- R8: In timer mode, `stop_cmd` only clears `tc_flag`. The count and `ct_out` keep going. A stop wins over a reload that happens in the same cycle.
- R9: `ext_pin` passes through two synchronizing flip-flops and its rising edge is the tick. A rising edge set up before clock edge k takes effect in the count at edge k+2.
- R10: The clock divider gives exactly one tick in every 16 cycles. The pin divider gives exactly one tick in every 16 pin rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Mode and tick-source code |
| preload_we | input | 1 | Write strobe for the preload value |
| preload_din | input | 16 | Preload value to store |
| start_cmd | input | 1 | Start/reload command strobe |
| stop_cmd | input | 1 | Stop command strobe |
| ext_pin | input | 1 | Asynchronous external tick pin |
| txa_tick | input | 1 | Channel A transmit 1x clock enable |
| txb_tick | input | 1 | Channel B transmit 1x clock enable |
| ct_out | output | 1 | Counter/timer output bit |
| tc_flag | output | 1 | Terminal-count flag |

## Verification
The counter is driven with tick pulses on the selected enable and on the unselected enable. This separates correct source selection from plain tick counting. It is also ticked after it has been halted, and it is given start and stop in the same cycle. Extra ticks and a second start after terminal count show that the low output is latched. The pin path is stepped one edge at a time so that an off-by-one in the synchronizer latency shows up. The timer is run from the pin and from the clock with known reload phases, which pins down the exact toggle cycles and the stop-only-clears-flag rule. Both divide-by-16 paths are checked by counting output toggles over windows that hold exactly a whole number of divided ticks, whatever the divider phase.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;

  typedef enum logic [2:0] {
    SRC_PIN     = 3'd0,
    SRC_PIN_DIV = 3'd1,
    SRC_TXA     = 3'd2,
    SRC_TXB     = 3'd3,
    SRC_CLK     = 3'd4,
    SRC_CLK_DIV = 3'd5
  } src_e;

  typedef struct packed {
    logic timer;
    src_e src;
  } cfg_t;

  // Mode code: bit 2 chooses timer/counter, full code chooses the tick source.
  function automatic cfg_t decode_mode(input logic [2:0] m);
    cfg_t c;
    c.timer = m[2];
    case (m)
      3'b000:  c.src = SRC_PIN;
      3'b001:  c.src = SRC_TXA;
      3'b010:  c.src = SRC_TXB;
      3'b011:  c.src = SRC_CLK_DIV;
      3'b100:  c.src = SRC_PIN;
      3'b101:  c.src = SRC_PIN_DIV;
      3'b110:  c.src = SRC_CLK;
      default: c.src = SRC_CLK_DIV;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  // Synchronizer chain plus one history flop for edge detection.
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam logic [DIV_LOG2-1:0] INC = DIV_LOG2'(1);

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + INC;
  end

  assign tick = en && (cnt_q == '1);

endmodule

// File: rtl/ct_core.sv
module ct_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             timer_mode,
  input  logic             src_tick,
  input  logic             preload_we,
  input  logic [CNT_W-1:0] preload_din,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  output logic             ct_out,
  output logic             tc_flag
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             out_q;
  logic             tc_q;
  logic             at_last;

  // Count of 1 or 0 is the last step before terminal count / reload.
  assign at_last = (count_q[CNT_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= '0;
      count_q   <= '0;
      run_q     <= 1'b0;
      out_q     <= 1'b1;
      tc_q      <= 1'b0;
    end else begin
      if (preload_we) preload_q <= preload_din;

      if (!timer_mode) begin
        // One-shot counter
        if (stop_cmd) begin
          run_q <= 1'b0;
          out_q <= 1'b1;
          tc_q  <= 1'b0;
        end else if (start_cmd) begin
          count_q <= preload_q;
          run_q   <= 1'b1;
        end else if (run_q && src_tick) begin
          if (at_last) begin
            count_q <= '0;
            run_q   <= 1'b0;
            out_q   <= 1'b0;
            tc_q    <= 1'b1;
          end else begin
            count_q <= count_q - STEP;
          end
        end
      end else begin
        // Free-running square-wave timer
        if (start_cmd) begin
          count_q <= preload_q;
        end else if (src_tick) begin
          if (at_last) begin
            count_q <= preload_q;
            out_q   <= ~out_q;
            tc_q    <= 1'b1;
          end else begin
            count_q <= count_q - STEP;
          end
        end
        if (stop_cmd) tc_q <= 1'b0;
      end
    end
  end

  assign ct_out  = out_q;
  assign tc_flag = tc_q;

endmodule

// File: rtl/ctr_timer.sv
module ctr_timer
  import ctr_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_sel,
  input  logic             preload_we,
  input  logic [CNT_W-1:0] preload_din,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             ext_pin,
  input  logic             txa_tick,
  input  logic             txb_tick,
  output logic             ct_out,
  output logic             tc_flag
);

  cfg_t cfg;
  logic pin_rise;
  logic pin_div_tick;
  logic clk_div_tick;
  logic src_tick;

  assign cfg = decode_mode(mode_sel);

  ct_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (pin_rise)
  );

  ct_prescale #(.DIV_LOG2(DIV_LOG2)) u_pin_div (
    .clk  (clk),
    .rst  (rst),
    .en   (pin_rise),
    .tick (pin_div_tick)
  );

  ct_prescale #(.DIV_LOG2(DIV_LOG2)) u_clk_div (
    .clk  (clk),
    .rst  (rst),
    .en   (1'b1),
    .tick (clk_div_tick)
  );

  always_comb begin
    case (cfg.src)
      SRC_PIN:     src_tick = pin_rise;
      SRC_PIN_DIV: src_tick = pin_div_tick;
      SRC_TXA:     src_tick = txa_tick;
      SRC_TXB:     src_tick = txb_tick;
      SRC_CLK:     src_tick = 1'b1;
      SRC_CLK_DIV: src_tick = clk_div_tick;
      default:     src_tick = 1'b0;
    endcase
  end

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .timer_mode  (cfg.timer),
    .src_tick    (src_tick),
    .preload_we  (preload_we),
    .preload_din (preload_din),
    .start_cmd   (start_cmd),
    .stop_cmd    (stop_cmd),
    .ct_out      (ct_out),
    .tc_flag     (tc_flag)
  );

endmodule

// File: rtl/ctr_timer_chk.sv
module ctr_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_sel,
  input logic       stop_cmd,
  input logic       ct_out,
  input logic       tc_flag
);

  logic rst_seen_q;

  always_ff @(posedge clk) rst_seen_q <= rst;

  always @(negedge clk) begin
    if (rst_seen_q === 1'b1) begin
      AST_RESET_VALUES: assert (ct_out && !tc_flag) else $error("reset values"); // R1
    end
  end

  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_sel[2]) && $fell(ct_out)) |-> tc_flag) else $error("fall without flag"); // R3

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel[2] && !ct_out && !stop_cmd) |=> !ct_out) else $error("low not held"); // R4

  AST_STOP_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel[2] && stop_cmd) |=> (ct_out && !tc_flag)) else $error("stop did not restore"); // R5

  AST_TOGGLE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_sel[2]) && !$past(stop_cmd) && (ct_out != $past(ct_out))) |-> tc_flag)
    else $error("toggle without flag"); // R7

  AST_TIMER_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[2] && stop_cmd) |=> !tc_flag) else $error("timer stop kept flag"); // R8

endmodule

bind ctr_timer ctr_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .stop_cmd (stop_cmd),
  .ct_out   (ct_out),
  .tc_flag  (tc_flag)
);

// File: tb/ctr_timer_tb.sv
module ctr_timer_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode_sel;
  logic        preload_we;
  logic [15:0] preload_din;
  logic        start_cmd;
  logic        stop_cmd;
  logic        ext_pin;
  logic        txa_tick;
  logic        txb_tick;
  logic        ct_out;
  logic        tc_flag;

  always #5 clk = ~clk;

  ctr_timer u_dut (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .preload_we  (preload_we),
    .preload_din (preload_din),
    .start_cmd   (start_cmd),
    .stop_cmd    (stop_cmd),
    .ext_pin     (ext_pin),
    .txa_tick    (txa_tick),
    .txb_tick    (txb_tick),
    .ct_out      (ct_out),
    .tc_flag     (tc_flag)
  );

  int n_chk = 0;
  int n_err = 0;
  int toggles = 0;

  typedef struct {
    logic  o;
    logic  t;
    string req;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  always @(ct_out) if (rst === 1'b0) toggles++;

  // Monitor: pops expected items and compares against the ports.
  initial begin : monitor
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (ct_out !== e.o || tc_flag !== e.t) begin
          n_err++;
          $display("FAIL %s: out=%b tc=%b expected out=%b tc=%b", e.req, ct_out, tc_flag, e.o, e.t);
        end
      end
    end
  end

  task automatic sb_expect(input logic o, input logic t, input string req);
    sb_q.push_back('{o, t, req});
    -> sample_ev;
    #1;
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_a(input int n);
    repeat (n) begin txa_tick = 1'b1; @(negedge clk); txa_tick = 1'b0; end
  endtask

  task automatic pulse_b(input int n);
    repeat (n) begin txb_tick = 1'b1; @(negedge clk); txb_tick = 1'b0; end
  endtask

  task automatic do_start();
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
  endtask

  task automatic do_stop();
    stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
  endtask

  task automatic load_pre(input logic [15:0] v);
    preload_we = 1'b1; preload_din = v; @(negedge clk); preload_we = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_sel = m; @(negedge clk);
  endtask

  task automatic ext_edges(input int n);
    repeat (n) begin
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : driver
    logic o0;
    int   t0;
    rst = 1'b1; mode_sel = 3'b001; preload_we = 1'b0; preload_din = '0;
    start_cmd = 1'b0; stop_cmd = 1'b0; ext_pin = 1'b0; txa_tick = 1'b0; txb_tick = 1'b0;
    repeat (3) @(negedge clk);
    sb_expect(1'b1, 1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    sb_expect(1'b1, 1'b0, "R1");

    // R3 / R4 / R5: one-shot counter from channel A tick
    load_pre(16'd3);
    do_start();
    sb_expect(1'b1, 1'b0, "R3");
    pulse_a(2);
    sb_expect(1'b1, 1'b0, "R3");
    pulse_a(1);
    sb_expect(1'b0, 1'b1, "R3");
    pulse_a(2);
    sb_expect(1'b0, 1'b1, "R4");
    do_start();
    pulse_a(3);
    sb_expect(1'b0, 1'b1, "R4");
    do_stop();
    sb_expect(1'b1, 1'b0, "R5");

    // R6: halted ticks and unselected source ignored
    pulse_a(4);
    sb_expect(1'b1, 1'b0, "R6");
    do_start();
    pulse_b(3);
    sb_expect(1'b1, 1'b0, "R6");
    pulse_a(3);
    sb_expect(1'b0, 1'b1, "R2");
    do_stop();

    // R5: stop wins over simultaneous start
    start_cmd = 1'b1; stop_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0; stop_cmd = 1'b0;
    pulse_a(3);
    sb_expect(1'b1, 1'b0, "R5");

    // R2: channel B source
    load_pre(16'd1);
    set_mode(3'b010);
    do_start();
    pulse_b(1);
    sb_expect(1'b0, 1'b1, "R2");
    do_stop();

    // R3: preload of zero behaves as one
    set_mode(3'b001);
    load_pre(16'd0);
    do_start();
    pulse_a(1);
    sb_expect(1'b0, 1'b1, "R3");
    do_stop();

    // R9: pin synchronizer latency
    set_mode(3'b000);
    load_pre(16'd1);
    do_start();
    ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sb_expect(1'b1, 1'b0, "R9");
    @(negedge clk);
    sb_expect(1'b0, 1'b1, "R9");
    ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    do_stop();

    // R10: counter from clock / 16
    set_mode(3'b011);
    load_pre(16'd2);
    do_start();
    repeat (16) @(negedge clk);
    sb_expect(1'b1, 1'b0, "R10");
    repeat (16) @(negedge clk);
    sb_expect(1'b0, 1'b1, "R10");
    do_stop();

    // R7 / R8: timer on every clock
    set_mode(3'b110);
    load_pre(16'd3);
    do_stop();
    do_start();
    o0 = ct_out;
    repeat (2) @(negedge clk);
    sb_expect(o0, 1'b0, "R7");
    @(negedge clk);
    sb_expect(!o0, 1'b1, "R7");
    repeat (3) @(negedge clk);
    sb_expect(o0, 1'b1, "R7");
    stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
    sb_expect(o0, 1'b0, "R8");
    repeat (2) @(negedge clk);
    sb_expect(!o0, 1'b1, "R8");

    // R7 / R9: timer on pin rising edges
    set_mode(3'b100);
    load_pre(16'd2);
    do_stop();
    do_start();
    o0 = ct_out;
    ext_edges(1);
    sb_expect(o0, 1'b0, "R7");
    ext_edges(1);
    sb_expect(!o0, 1'b1, "R9");
    ext_edges(2);
    sb_expect(o0, 1'b1, "R7");

    // R10: timer on clock / 16
    set_mode(3'b111);
    load_pre(16'd1);
    do_start();
    t0 = toggles;
    repeat (64) @(negedge clk);
    check_int(toggles - t0, 4, "R10");

    // R10: timer on pin edges / 16
    set_mode(3'b101);
    do_start();
    t0 = toggles;
    ext_edges(32);
    check_int(toggles - t0, 2, "R10");

    #20;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule